// File: doc/BRIEF.md
# Pipeline Exception Status Tracker

This block follows an exception status code through the pipeline registers of a five-stage in-order core (fetch, decode, execute, memory, write-back). Fetch gives each instruction a code. Decode and execute carry the code forward unchanged. The memory stage can replace a clean code with an address-fault code when a data access is invalid. The exception is reported only when the faulting instruction reaches write-back. This keeps exceptions precise: a faulting fetch on a path that is later squashed is never reported, and an older fault always wins over a younger one.

The block also gates the architectural state updates that surround a fault. The condition-code write enable in execute drops when the memory stage or write-back holds an exception code. The data-memory write enable drops for a faulting access and while write-back holds an exception. Once the exception is reported, every status register freezes until reset. The hazard unit drives the per-register stall and bubble controls. A bubble loads a distinct bubble code, which never faults and never gates anything.

Top module: `pipe_exc_tracker`

## Requirements
- R1: In reset, every status register holds the bubble code, exc_taken is 0, exc_status is 1, and e_cc_en and m_mem_en are 0.
- R2: The status codes are AOK=0, BUB=1, HLT=2, ADR=3 and INS=4. Fetch assigns ADR when f_bad_addr is set, else INS when f_bad_instr is set, else HLT when f_halt is set, else AOK.
- R3: With no stalls or bubbles, a code enters the decode register at the first clock edge and reaches write-back at the fourth edge, unchanged.
- R4: The memory stage turns AOK into ADR when m_addr_err is high. It passes any other incoming code through, so m_addr_err has no effect on a bubble or on an already faulted instruction.
- R5: exc_taken is high exactly when write-back holds HLT, ADR or INS. exc_status always shows the write-back code.
- R6: e_cc_en is high only when execute holds AOK, the memory-stage code after its address check is not an exception, and write-back holds no exception.
- R7: m_mem_en is high only when the memory-stage code after its address check is AOK and write-back holds no exception.
- R8: Bit i of bubble_i loads BUB into register i (0=decode, 1=execute, 2=memory, 3=write-back). Bit i of stall_i holds register i, and a stall wins over a bubble. A BUB code never raises an exception.
- R9: A faulting fetch that is squashed by bubbles before execute never raises an exception.
- R10: After exc_taken rises, all status registers hold their values until reset. exc_status stays constant and both enables stay 0, whatever the inputs do.
- R11: When an older instruction faults in memory and a younger one faulted in fetch, the older fault's code is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| f_bad_addr | input | 1 | Fetch address invalid |
| f_bad_instr | input | 1 | Fetched opcode invalid |
| f_halt | input | 1 | Fetched instruction is a halt |
| m_addr_err | input | 1 | Data access address in the memory stage is invalid |
| stall_i | input | 4 | Per-register hold (0=decode … 3=write-back) |
| bubble_i | input | 4 | Per-register bubble insert (0=decode … 3=write-back) |
| e_cc_en | output | 1 | Execute may update condition codes |
| m_mem_en | output | 1 | Memory stage may write data memory |
| exc_taken | output | 1 | Faulting instruction is in write-back |
| exc_status | output | 3 | Status code held in write-back |

## Verification
The assertions check four things on every cycle. The exception flag must agree with the write-back code. Both enables must be off while an exception sits in write-back or an address fault is signalled. The state must stay frozen after the fault. Codes must pass through execute unchanged, and a bubble must load into write-back. Other behaviour is shown only by the bench's scenarios: the exact edge at which each fetch and memory fault becomes visible, the fetch priority among the fault flags, the squashing of a faulting fetch on a wrong path, the effect of a stall on timing, and the precedence of an older memory fault over a younger fetch fault.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int STAT_W   = 3;
    localparam int NUM_REGS = 4;   // decode, execute, memory, write-back

    typedef enum logic [STAT_W-1:0] {
        ST_AOK = 3'd0,
        ST_BUB = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } status_t;

    function automatic logic is_fault(status_t s);
        return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
    endfunction

endpackage

// File: rtl/exc_fetch_status.sv
module exc_fetch_status
    import exc_pkg::*;
(
    input  logic    bad_addr,
    input  logic    bad_instr,
    input  logic    halt,
    output status_t stat
);
    // Priority: an unreadable address leaves no opcode to judge.
    always_comb begin
        if (bad_addr)       stat = ST_ADR;
        else if (bad_instr) stat = ST_INS;
        else if (halt)      stat = ST_HLT;
        else                stat = ST_AOK;
    end
endmodule

// File: rtl/exc_mem_status.sv
module exc_mem_status
    import exc_pkg::*;
(
    input  status_t stat_in,
    input  logic    addr_err,
    output status_t stat_out
);
    // Only a clean instruction can acquire a data-address fault.
    always_comb begin
        if (stat_in == ST_AOK && addr_err) stat_out = ST_ADR;
        else                               stat_out = stat_in;
    end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  logic    bubble,
    input  status_t d,
    output status_t q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= ST_BUB;
        else if (hold)   q <= q;
        else if (bubble) q <= ST_BUB;
        else             q <= d;
    end
endmodule

// File: rtl/pipe_exc_tracker.sv
module pipe_exc_tracker
    import exc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                f_bad_addr,
    input  logic                f_bad_instr,
    input  logic                f_halt,
    input  logic                m_addr_err,
    input  logic [NUM_REGS-1:0] stall_i,
    input  logic [NUM_REGS-1:0] bubble_i,
    output logic                e_cc_en,
    output logic                m_mem_en,
    output logic                exc_taken,
    output logic [STAT_W-1:0]   exc_status
);
    localparam int IDX_D = 0;
    localparam int IDX_E = 1;
    localparam int IDX_M = 2;
    localparam int IDX_W = NUM_REGS - 1;

    status_t f_stat;
    status_t m_stat;
    status_t st_d [NUM_REGS];
    status_t st_q [NUM_REGS];
    status_t d_stat, e_stat, mq_stat, w_stat;
    logic    frozen;

    exc_fetch_status u_fetch (
        .bad_addr  (f_bad_addr),
        .bad_instr (f_bad_instr),
        .halt      (f_halt),
        .stat      (f_stat)
    );

    exc_mem_status u_mem (
        .stat_in  (st_q[IDX_M]),
        .addr_err (m_addr_err),
        .stat_out (m_stat)
    );

    assign frozen = is_fault(st_q[IDX_W]);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_src_fetch
            assign st_d[i] = f_stat;
        end else if (i == IDX_W) begin : g_src_mem
            assign st_d[i] = m_stat;
        end else begin : g_src_prev
            assign st_d[i] = st_q[i-1];
        end

        exc_stage_reg u_reg (
            .clk    (clk),
            .rst    (rst),
            .hold   (stall_i[i] | frozen),
            .bubble (bubble_i[i]),
            .d      (st_d[i]),
            .q      (st_q[i])
        );
    end

    assign d_stat  = st_q[IDX_D];
    assign e_stat  = st_q[IDX_E];
    assign mq_stat = st_q[IDX_M];
    assign w_stat  = st_q[IDX_W];

    assign e_cc_en    = (e_stat == ST_AOK) && !is_fault(m_stat) && !frozen;
    assign m_mem_en   = (m_stat == ST_AOK) && !frozen;
    assign exc_taken  = frozen;
    assign exc_status = w_stat;
endmodule

// File: rtl/pipe_exc_tracker_chk.sv
module pipe_exc_tracker_chk
    import exc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                m_addr_err,
    input logic [NUM_REGS-1:0] stall_i,
    input logic [NUM_REGS-1:0] bubble_i,
    input logic                e_cc_en,
    input logic                m_mem_en,
    input logic                exc_taken,
    input logic [STAT_W-1:0]   exc_status,
    input status_t             d_stat,
    input status_t             e_stat,
    input status_t             mq_stat
);
    assert_flag_code_R5: assert property (@(posedge clk) disable iff (rst)
        exc_taken == (exc_status == 3'd2 || exc_status == 3'd3 || exc_status == 3'd4));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        exc_taken |=> (exc_taken && $stable(exc_status)));

    assert_gate_on_fault_R10: assert property (@(posedge clk) disable iff (rst)
        exc_taken |-> (!e_cc_en && !m_mem_en));

    assert_no_store_on_err_R7: assert property (@(posedge clk) disable iff (rst)
        m_addr_err |-> !m_mem_en);

    assert_cc_needs_clean_R6: assert property (@(posedge clk) disable iff (rst)
        e_cc_en |-> (e_stat == ST_AOK && !(mq_stat == ST_AOK && m_addr_err)));

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
        (!exc_taken && !stall_i[1] && !bubble_i[1]) |=> (e_stat == $past(d_stat)));

    assert_bubble_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!exc_taken && bubble_i[3] && !stall_i[3]) |=> (exc_status == 3'd1 && !exc_taken));
endmodule

bind pipe_exc_tracker pipe_exc_tracker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .m_addr_err (m_addr_err),
    .stall_i    (stall_i),
    .bubble_i   (bubble_i),
    .e_cc_en    (e_cc_en),
    .m_mem_en   (m_mem_en),
    .exc_taken  (exc_taken),
    .exc_status (exc_status),
    .d_stat     (d_stat),
    .e_stat     (e_stat),
    .mq_stat    (mq_stat)
);

// File: tb/pipe_exc_tracker_tb.sv
module pipe_exc_tracker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       f_bad_addr = 1'b0, f_bad_instr = 1'b0, f_halt = 1'b0;
    logic       m_addr_err = 1'b0;
    logic [3:0] stall_i = 4'd0, bubble_i = 4'd0;
    logic       e_cc_en, m_mem_en, exc_taken;
    logic [2:0] exc_status;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    pipe_exc_tracker u_dut (
        .clk(clk), .rst(rst),
        .f_bad_addr(f_bad_addr), .f_bad_instr(f_bad_instr), .f_halt(f_halt),
        .m_addr_err(m_addr_err), .stall_i(stall_i), .bubble_i(bubble_i),
        .e_cc_en(e_cc_en), .m_mem_en(m_mem_en),
        .exc_taken(exc_taken), .exc_status(exc_status)
    );

    // {bad_addr, bad_instr, halt, mem_err}
    localparam logic [3:0] VEC [8] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011,
                                        4'b0100, 4'b1000, 4'b1100, 4'b1111};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        f_bad_addr = 0; f_bad_instr = 0; f_halt = 0;
        m_addr_err = 0; stall_i = 0; bubble_i = 0;
    endtask

    task automatic do_reset();
        clear_in();
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    function automatic int exp_code(input logic [3:0] v);
        if (v[3]) return 3;
        if (v[2]) return 4;
        if (v[1]) return 2;
        if (v[0]) return 3;
        return 0;
    endfunction

    function automatic int is_exc(input int c);
        return (c == 2 || c == 3 || c == 4) ? 1 : 0;
    endfunction

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset();
        rst = 1;
        tick();
        // R1 reset state
        check("R1 exc_taken", int'(exc_taken), 0);
        check("R1 exc_status", int'(exc_status), 1);
        check("R1 e_cc_en", int'(e_cc_en), 0);
        check("R1 m_mem_en", int'(m_mem_en), 0);

        // R2 R3 R4 R5 R6 R7: table walk
        foreach (VEC[k]) begin
            do_reset();
            {f_bad_addr, f_bad_instr, f_halt} = VEC[k][3:1];
            tick();                      // edge1: decode
            clear_in();
            tick();                      // edge2: execute
            tick();                      // edge3: memory
            m_addr_err = VEC[k][0];
            #0;
            check("R6 cc_en with target in memory", int'(e_cc_en),
                  1 - is_exc(exp_code(VEC[k])));
            check("R7 mem_en with target in memory", int'(m_mem_en),
                  (exp_code(VEC[k]) == 0) ? 1 : 0);
            check("R3 not yet in write-back", int'(exc_taken), 0);
            tick();                      // edge4: write-back
            m_addr_err = 0;
            check("R2 R4 write-back code", int'(exc_status), exp_code(VEC[k]));
            check("R5 exc_taken", int'(exc_taken), is_exc(exp_code(VEC[k])));
        end

        // R10 freeze after an INS fault
        do_reset();
        f_bad_instr = 1;
        tick();
        clear_in();
        repeat (3) tick();
        check("R10 taken", int'(exc_taken), 1);
        f_bad_addr = 1; m_addr_err = 1; bubble_i = 4'hF;
        repeat (4) tick();
        check("R10 status held", int'(exc_status), 4);
        check("R10 taken held", int'(exc_taken), 1);
        check("R10 cc_en off", int'(e_cc_en), 0);
        check("R10 mem_en off", int'(m_mem_en), 0);

        // R9 squashed faulting fetch
        do_reset();
        f_bad_addr = 1;
        tick();
        clear_in();
        bubble_i = 4'b0011;
        tick();
        clear_in();
        for (int j = 0; j < 5; j++) begin
            tick();
            check("R9 no exception from squashed fetch", int'(exc_taken), 0);
        end
        check("R9 write-back clean", int'(exc_status), 0);

        // R8 stall in decode delays the fault by two cycles
        do_reset();
        f_bad_instr = 1;
        tick();
        clear_in();
        stall_i = 4'b0001; bubble_i = 4'b0010;
        tick();
        tick();
        clear_in();
        tick();                          // fault now in execute
        check("R8 stalled fault not in write-back", int'(exc_taken), 0);
        tick();
        check("R8 bubble ahead of fault", int'(exc_status), 1);
        tick();
        check("R8 delayed fault taken", int'(exc_taken), 1);
        check("R8 delayed fault code", int'(exc_status), 4);

        // R4 R8 address error against a bubble in memory
        do_reset();
        m_addr_err = 1;
        #0;
        check("R7 mem_en with bubble in memory", int'(m_mem_en), 0);
        tick();
        clear_in();
        check("R4 bubble ignores addr error", int'(exc_taken), 0);
        check("R8 bubble code in write-back", int'(exc_status), 1);

        // R11 older memory fault wins over younger fetch fault
        do_reset();
        tick();                          // older clean instruction in decode
        f_bad_instr = 1;                 // younger faulty fetch
        tick();
        clear_in();
        tick();                          // older in memory
        m_addr_err = 1;
        tick();
        m_addr_err = 0;
        check("R11 older fault reported", int'(exc_status), 3);
        tick();
        check("R11 younger fault suppressed", int'(exc_status), 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule